// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Controller

This block is the digital protection sequencer for one channel of a switching regulator. It watches a high-side overcurrent comparator once per switching cycle. A single trip blanks the high-side switch for the rest of that cycle. A run of consecutive tripping cycles shuts the channel down into a timed hiccup pause. After the pause the channel asks the soft-start generator for a fresh ramp.

A separate path handles reverse inductor current. When the negative-current comparator fires, the stage is tri-stated and the output is pulled down. Switching resumes as soon as the output is reported back in regulation. Each regulator channel gets its own instance. The comparators, the soft-start ramp and the power stage sit outside the block and talk to it through single-bit strobes and levels.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset the block is in run state (`fault_state` = 2'b00) with `sw_en` high, and with `hs_kill`, `tri_req`, `oc_flag`, `ss_restart` low and `trip_count` zero.
- R2: In run state, `ocp_trip` drives `hs_kill` high from the next clock. `hs_kill` stays high until a `cyc_start` arrives without a trip, and it falls on the clock after that `cyc_start`.
- R3: The first `ocp_trip` of a switching cycle adds one to `trip_count` (the first trip of a run gives 1) and raises `oc_flag` on the next clock. Further trips in the same cycle do not count. A trip that coincides with `cyc_start` belongs to the new cycle.
- R4: A `cyc_start` that ends a cycle with no trip in it clears `trip_count` to zero.
- R5: On a trip-free cycle end, `oc_flag` falls if `trip_count` is below FLAG_HOLD_AT (default 4). Otherwise `oc_flag` stays high, and it falls at the next trip-free cycle end.
- R6: The trip that makes TRIP_LIMIT (default 17) consecutive tripping cycles moves the block to hiccup wait (`fault_state` = 2'b01) on the next clock. In hiccup wait `hs_kill` and `tri_req` are high and `sw_en` is low.
- R7: Hiccup wait lasts exactly WAIT_PERIODS × SS_TICKS clocks. During the wait, `cyc_start`, `ocp_trip` and `neg_trip` have no effect, and `trip_count` holds at TRIP_LIMIT.
- R8: Leaving hiccup wait returns the block to run state with `trip_count` and `oc_flag` cleared, and gives a one-clock `ss_restart` pulse. The hiccup sequence repeats every time the fault builds up again.
- R9: `neg_trip` in run state moves the block to tri-state (`fault_state` = 2'b10) on the next clock. This sets `tri_req` and `hs_kill` high, sets `sw_en` low and clears `trip_count`. `neg_trip` wins over a trip that reaches TRIP_LIMIT on the same clock.
- R10: In tri-state, `cyc_start` and `ocp_trip` are ignored. The block returns to run state on the clock after `vout_in_reg` is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| ocp_trip | input | 1 | High-side overcurrent comparator trip |
| neg_trip | input | 1 | Negative current limit trip |
| vout_in_reg | input | 1 | Output voltage is within regulation |
| hs_kill | output | 1 | Forces the high-side switch off |
| sw_en | output | 1 | Switching allowed |
| tri_req | output | 1 | Request tri-state of the stage and output discharge |
| ss_restart | output | 1 | One-clock request to start a new soft-start ramp |
| oc_flag | output | 1 | Overcurrent condition flag |
| fault_state | output | 2 | 00 run, 01 hiccup wait, 10 negative-current tri-state |
| trip_count | output | $clog2(TRIP_LIMIT+1) | Consecutive tripping-cycle count |

## Verification
Every output is registered or decoded from registered state, so a stimulus applied in one cycle shows up one clock later. This holds for the trip count, the flag, the high-side kill and every state change. The single exception is the hiccup exit, which is due exactly WAIT_PERIODS × SS_TICKS clocks after the clock that entered the wait. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. This gives each expected value exactly one register stage. The wait is checked on every cycle up to its last one, on the exit cycle, and on the cycle after the exit, so a wait that is one clock short or one clock long is caught.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_WAIT = 2'b01,
      ST_NEG  = 2'b10
   } hic_state_e;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/ocp_trip_tracker.sv
module ocp_trip_tracker #(
   parameter int TRIP_LIMIT   = 17,
   parameter int FLAG_HOLD_AT = 4,
   parameter int CW           = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          cyc_start,
   input  logic          ocp_trip,
   input  logic          clr_cnt,
   input  logic          clr_flag,
   output logic [CW-1:0] cnt_q,
   output logic          kill_q,
   output logic          flag_q,
   output logic          limit_now
);
   localparam logic [CW-1:0] LIMIT_M1 = CW'(TRIP_LIMIT - 1);
   localparam logic [CW-1:0] HOLD_V   = CW'(FLAG_HOLD_AT);
   localparam logic [CW-1:0] ONE      = CW'(1);

   logic          hit_q;
   logic          base_hit;
   logic [CW-1:0] base_cnt;
   logic          new_trip;
   logic          clean_close;

   always_comb begin
      base_hit    = cyc_start ? 1'b0 : hit_q;
      clean_close = cyc_start && !hit_q;
      base_cnt    = clean_close ? '0 : cnt_q;
      new_trip    = run && ocp_trip && !base_hit;
      limit_now   = new_trip && (base_cnt == LIMIT_M1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hit_q  <= 1'b0;
         kill_q <= 1'b0;
      end else if (clr_cnt) begin
         cnt_q  <= '0;
         hit_q  <= 1'b0;
         kill_q <= 1'b0;
      end else if (run) begin
         cnt_q  <= new_trip ? base_cnt + ONE : base_cnt;
         hit_q  <= base_hit | new_trip;
         kill_q <= ocp_trip | (kill_q & !cyc_start);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (clr_flag) begin
         flag_q <= 1'b0;
      end else if (run && !clr_cnt) begin
         if (new_trip)
            flag_q <= 1'b1;
         else if (clean_close && (cnt_q < HOLD_V))
            flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
   parameter int SS_TICKS     = 162500,
   parameter int WAIT_PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic done
);
   logic tick_last;
   logic per_last;

   generate
      if (SS_TICKS > 1) begin : g_tick
         localparam int TW = $clog2(SS_TICKS);
         localparam logic [TW-1:0] TLAST = TW'(SS_TICKS - 1);
         logic [TW-1:0] tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tick_q <= '0;
            else if (!active || tick_last)
               tick_q <= '0;
            else
               tick_q <= tick_q + TW'(1);
         end
         assign tick_last = (tick_q == TLAST);
      end else begin : g_notick
         assign tick_last = 1'b1;
      end

      if (WAIT_PERIODS > 1) begin : g_per
         localparam int PW = $clog2(WAIT_PERIODS);
         localparam logic [PW-1:0] PLAST = PW'(WAIT_PERIODS - 1);
         logic [PW-1:0] per_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               per_q <= '0;
            else if (!active)
               per_q <= '0;
            else if (tick_last && !per_last)
               per_q <= per_q + PW'(1);
         end
         assign per_last = (per_q == PLAST);
      end else begin : g_noper
         assign per_last = 1'b1;
      end
   endgenerate

   assign done = active && tick_last && per_last;

endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
   import ocp_hiccup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       neg_trip,
   input  logic       in_reg,
   input  logic       limit_now,
   input  logic       wait_done,
   output hic_state_e state_q,
   output logic       enter_neg,
   output logic       restart,
   output logic       ss_pulse_q
);
   hic_state_e state_d;

   always_comb begin
      state_d   = state_q;
      enter_neg = 1'b0;
      restart   = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (neg_trip) begin
               state_d   = ST_NEG;
               enter_neg = 1'b1;
            end else if (limit_now) begin
               state_d = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (wait_done) begin
               state_d = ST_RUN;
               restart = 1'b1;
            end
         end
         ST_NEG: begin
            if (in_reg)
               state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         ss_pulse_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         ss_pulse_q <= restart;
      end
   end

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
   import ocp_hiccup_pkg::*;
#(
   parameter int TRIP_LIMIT   = 17,
   parameter int FLAG_HOLD_AT = 4,
   parameter int WAIT_PERIODS = 4,
   parameter int SS_TICKS     = 162500,
   localparam int CW          = cnt_width(TRIP_LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_start,
   input  logic          ocp_trip,
   input  logic          neg_trip,
   input  logic          vout_in_reg,
   output logic          hs_kill,
   output logic          sw_en,
   output logic          tri_req,
   output logic          ss_restart,
   output logic          oc_flag,
   output logic [1:0]    fault_state,
   output logic [CW-1:0] trip_count
);
   generate
      if (TRIP_LIMIT < 2) begin : g_bad_limit
         $error("TRIP_LIMIT must be at least 2");
      end
      if (FLAG_HOLD_AT < 1 || FLAG_HOLD_AT > TRIP_LIMIT) begin : g_bad_hold
         $error("FLAG_HOLD_AT must lie in 1..TRIP_LIMIT");
      end
      if (WAIT_PERIODS < 1 || SS_TICKS < 1) begin : g_bad_wait
         $error("WAIT_PERIODS and SS_TICKS must be positive");
      end
   endgenerate

   hic_state_e state_q;
   logic       run;
   logic       limit_now;
   logic       wait_done;
   logic       enter_neg;
   logic       restart;
   logic       kill_q;

   assign run = (state_q == ST_RUN);

   ocp_trip_tracker #(
      .TRIP_LIMIT   (TRIP_LIMIT),
      .FLAG_HOLD_AT (FLAG_HOLD_AT),
      .CW           (CW)
   ) trk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .cyc_start (cyc_start),
      .ocp_trip  (ocp_trip),
      .clr_cnt   (enter_neg | restart),
      .clr_flag  (restart),
      .cnt_q     (trip_count),
      .kill_q    (kill_q),
      .flag_q    (oc_flag),
      .limit_now (limit_now)
   );

   ocp_hiccup_timer #(
      .SS_TICKS     (SS_TICKS),
      .WAIT_PERIODS (WAIT_PERIODS)
   ) tmr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == ST_WAIT),
      .done   (wait_done)
   );

   ocp_hiccup_fsm fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .neg_trip   (neg_trip),
      .in_reg     (vout_in_reg),
      .limit_now  (limit_now),
      .wait_done  (wait_done),
      .state_q    (state_q),
      .enter_neg  (enter_neg),
      .restart    (restart),
      .ss_pulse_q (ss_restart)
   );

   assign hs_kill     = kill_q | !run;
   assign sw_en       = run;
   assign tri_req     = !run;
   assign fault_state = state_q;

endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk #(
   parameter int TRIP_LIMIT = 17,
   parameter int CW         = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cyc_start,
   input logic          ocp_trip,
   input logic          neg_trip,
   input logic          vout_in_reg,
   input logic          hs_kill,
   input logic          sw_en,
   input logic          tri_req,
   input logic          ss_restart,
   input logic          oc_flag,
   input logic [1:0]    fault_state,
   input logic [CW-1:0] trip_count
);
   localparam logic [1:0]    S_RUN  = 2'b00;
   localparam logic [1:0]    S_WAIT = 2'b01;
   localparam logic [1:0]    S_NEG  = 2'b10;
   localparam logic [CW-1:0] CAP    = CW'(TRIP_LIMIT);

   AST_KILL_AFTER_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_RUN && ocp_trip) |=> hs_kill); // R2

   AST_FLAG_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_RUN && ocp_trip && !neg_trip) |=> oc_flag); // R3

   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      trip_count <= CAP); // R3

   AST_WAIT_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_WAIT) |-> (hs_kill && tri_req && !sw_en)); // R6

   AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_WAIT) |=> (fault_state != S_WAIT || $stable(trip_count))); // R7

   AST_WAIT_EXIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_WAIT) |=> (fault_state == S_WAIT || ss_restart)); // R8

   AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ss_restart |=> !ss_restart); // R8

   AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      ss_restart |-> (trip_count == '0 && !oc_flag && fault_state == S_RUN)); // R8

   AST_NEG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_RUN && neg_trip) |=> (fault_state == S_NEG && trip_count == '0)); // R9

   AST_NEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state == S_NEG && !vout_in_reg) |=> (fault_state == S_NEG && tri_req)); // R10

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk #(
   .TRIP_LIMIT (TRIP_LIMIT),
   .CW         (CW)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_start   (cyc_start),
   .ocp_trip    (ocp_trip),
   .neg_trip    (neg_trip),
   .vout_in_reg (vout_in_reg),
   .hs_kill     (hs_kill),
   .sw_en       (sw_en),
   .tri_req     (tri_req),
   .ss_restart  (ss_restart),
   .oc_flag     (oc_flag),
   .fault_state (fault_state),
   .trip_count  (trip_count)
);

// File: tb/ocp_hiccup_ctrl_tb_top.sv
module ocp_hiccup_ctrl_tb_top;
   localparam int LIMIT = 17;
   localparam int WPER  = 4;
   localparam int STCK  = 5;
   localparam int WAITN = WPER * STCK;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0, ocp_trip = 1'b0, neg_trip = 1'b0, vout_in_reg = 1'b0;
   logic       hs_kill, sw_en, tri_req, ss_restart, oc_flag;
   logic [1:0] fault_state;
   logic [4:0] trip_count;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   ocp_hiccup_ctrl #(
      .TRIP_LIMIT   (LIMIT),
      .FLAG_HOLD_AT (4),
      .WAIT_PERIODS (WPER),
      .SS_TICKS     (STCK)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_start   (cyc_start),
      .ocp_trip    (ocp_trip),
      .neg_trip    (neg_trip),
      .vout_in_reg (vout_in_reg),
      .hs_kill     (hs_kill),
      .sw_en       (sw_en),
      .tri_req     (tri_req),
      .ss_restart  (ss_restart),
      .oc_flag     (oc_flag),
      .fault_state (fault_state),
      .trip_count  (trip_count)
   );

   typedef struct packed {
      logic       cs;
      logic       ocp;
      logic       neg;
      logic       inr;
      logic [4:0] cnt;
      logic       flag;
      logic       kill;
      logic [1:0] st;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0}, // R4 idle cycle
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1, 1'b1, 2'd0}, // R2 R3 first trip
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1, 1'b1, 2'd0}, // R3 second trip same cycle
      '{1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b1, 2'd0}, // R2 kill held
      '{1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 2'd0}, // R2 kill drops at cycle start
      '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0}, // R4 R5 clean cycle, count 1
      '{1'b1, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1, 1'b1, 2'd0}, // R3 trip with cycle start
      '{1'b1, 1'b1, 1'b0, 1'b0, 5'd2, 1'b1, 1'b1, 2'd0}, // R3
      '{1'b1, 1'b1, 1'b0, 1'b0, 5'd3, 1'b1, 1'b1, 2'd0}, // R3
      '{1'b1, 1'b1, 1'b0, 1'b0, 5'd4, 1'b1, 1'b1, 2'd0}, // R3
      '{1'b1, 1'b0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 2'd0}, // R2 closes tripped cycle
      '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0}, // R5 flag held at count 4
      '{1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0}, // R5 flag drops later
      '{1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1, 2'd2}, // R9 tri-state entry
      '{1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 2'd2}, // R10 trips ignored
      '{1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 2'd0}  // R10 back in regulation
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic cs, input logic ocp, input logic neg, input logic inr);
      cyc_start   = cs;
      ocp_trip    = ocp;
      neg_trip    = neg;
      vout_in_reg = inr;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(fault_state == 2'b00 && sw_en && !hs_kill && !tri_req && !oc_flag &&
            !ss_restart && trip_count == 5'd0, "R1", "reset outputs",
            {hs_kill, sw_en, tri_req, ss_restart, oc_flag, fault_state}, 7'b0100000);

      // vector table: R2 R3 R4 R5 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [9:0] obs;
         logic [9:0] exp;
         drive(VECS[i].cs, VECS[i].ocp, VECS[i].neg, VECS[i].inr);
         obs = {trip_count, oc_flag, hs_kill, fault_state};
         exp = {VECS[i].cnt, VECS[i].flag, VECS[i].kill, VECS[i].st};
         check(obs == exp, $sformatf("R2/R3/R4/R5/R9/R10 row %0d", i), "cnt,flag,kill,st",
               obs, exp);
      end

      // R6 build up to the limit
      for (int n = 1; n <= LIMIT; n++) begin
         drive(1'b1, 1'b1, 1'b0, 1'b0);
         if (n == LIMIT - 1)
            check(trip_count == 5'(LIMIT - 1) && fault_state == 2'b00, "R3", "count before limit",
                  trip_count, LIMIT - 1);
      end
      check(fault_state == 2'b01 && hs_kill && tri_req && !sw_en && trip_count == 5'(LIMIT),
            "R6", "hiccup entry", {fault_state, trip_count}, {2'b01, 5'(LIMIT)});

      // R7 wait length, inputs ignored
      begin
         bit held = 1;
         for (int k = 1; k < WAITN; k++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b1);
            if (fault_state != 2'b01 || trip_count != 5'(LIMIT) || ss_restart) held = 0;
         end
         check(held, "R7", "wait held with stimulus", held, 1);
      end
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check(fault_state == 2'b00 && ss_restart && trip_count == 5'd0 && !oc_flag &&
            !hs_kill && sw_en && !tri_req, "R8", "restart at wait end",
            {fault_state, ss_restart, oc_flag}, 4'b0010);
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check(!ss_restart, "R8", "restart one clock", ss_restart, 0);

      // R8 second hiccup
      for (int n = 1; n <= LIMIT; n++) drive(1'b1, 1'b1, 1'b0, 1'b0);
      check(fault_state == 2'b01, "R8", "second hiccup entry", fault_state, 1);
      for (int k = 1; k < WAITN; k++) drive(1'b0, 1'b0, 1'b0, 1'b0);
      check(fault_state == 2'b01, "R7", "last wait cycle", fault_state, 1);
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check(fault_state == 2'b00 && ss_restart, "R8", "second restart",
            {fault_state, ss_restart}, 3'b001);

      // R9 negative trip beats limit
      for (int n = 1; n < LIMIT; n++) drive(1'b1, 1'b1, 1'b0, 1'b0);
      check(trip_count == 5'(LIMIT - 1), "R3", "count at limit-1", trip_count, LIMIT - 1);
      drive(1'b1, 1'b1, 1'b1, 1'b0);
      check(fault_state == 2'b10 && trip_count == 5'd0 && tri_req && hs_kill && !sw_en,
            "R9", "negative wins over limit", {fault_state, trip_count}, {2'b10, 5'd0});
      drive(1'b0, 1'b0, 1'b0, 1'b0);
      check(fault_state == 2'b10, "R10", "stays tri-state", fault_state, 2);
      drive(1'b0, 1'b0, 1'b0, 1'b1);
      check(fault_state == 2'b00 && sw_en && !hs_kill, "R10", "resume on regulation",
            fault_state, 0);

      finished = 1;
      report();
   end

endmodule